// File: doc/BRIEF.md
# Universal serial shift unit

This block is a byte-wide serial shifter with a small edge counter, intended for full-duplex links that follow SPI modes 0 and 1 over separate data-in and data-out pins. A single shift clock drives both the shift register and the counter. That clock comes from one of three places: the external clock pin, a strobe from a timer compare match, or a strobe that software issues through the control register. When the counter rolls over from its top value to zero, it sets a sticky completion flag. That flag can raise an interrupt.

The unit can act as the clocking side of a link. In that case software produces the serial clock. It either flips the clock output with a toggle bit or writes the clock level directly. When the master bit is set, the unit's own clock output feeds its edge detector. Each edge on the pin clock counts once, so a full byte takes sixteen edges. A counter preset of 8 ends the transfer after eight edges. With the timer or software strobes, each strobe shifts one bit and counts once.

Slave-select handling is not part of the block. If it is needed, software can provide it.

Top module: `ssu_top`

## Requirements
- R1: After reset, all four registers read 0x00, and `sdo`, `sck_out` and `irq` are all 0.
- R2: The register map is: address 0 data, address 1 counter (zero-extended on read), address 2 control, address 3 status. Control fields are: [1:0] clock source (0 off, 1 pin, 2 timer, 3 software), [2] phase (0 = mode 0, 1 = mode 1), [3] interrupt enable, [4] clock toggle (write-only), [5] master, [6] software step (write-only). Both write-only bits read as 0. Status fields are: [0] completion flag, [1] clock output level.
- R3: In mode 0 with the pin source, a rising edge shifts `sdi` into bit 0 of the data register, and a falling edge moves the current bit 7 onto `sdo`. A write to the data register places the new bit 7 on `sdo` at once. Every edge adds one to the counter.
- R4: In mode 1 with the pin source, a rising edge moves the current bit 7 onto `sdo`, and a falling edge shifts `sdi` in. Every edge adds one to the counter.
- R5: When the counter advances from 15 to 0, the completion flag is set. The flag stays set until status bit 0 is written with 1. `irq` is high exactly when the flag and the interrupt enable are both set.
- R6: With the timer source, each `tmr_match` pulse shifts once and counts once, and `sdo` takes the new bit 7 in the same step. Pin edges and software steps have no effect.
- R7: With the software source, writing control with bit 6 set performs one shift and one count. The timer strobe has no effect.
- R8: Writing control with bit 4 set inverts `sck_out`. Writing status bit 1 sets `sck_out` to that value. When the master bit is set and the pin source is chosen, the edges of `sck_out` clock the unit instead of `sck_in`.
- R9: A host write to the counter or the data register takes priority over a shift-clock event in the same cycle.
- R10: With the clock source off, the counter and the data register do not change on any clock event.
- R11: Two units are linked with the master's `sck_out` to the peer's `sck_in` and the data pins crossed, both in mode 0. After eight clock periods (sixteen toggles), their data registers have swapped and both completion flags are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| sck_in | input | 1 | External serial clock pin |
| sck_out | output | 1 | Software-driven serial clock output |
| tmr_match | input | 1 | Timer compare-match strobe, one cycle wide |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest case to reach is the two-unit exchange. There the master's own clock toggles drive its shifter with one cycle of latency, while the peer sees the same edges three cycles later through its synchronizer. A byte swaps correctly only if every launch and every sample lands on the correct side of the other unit's events. The bench builds this case by instantiating a second unit as the peer and crossing the data pins. It then issues sixteen toggle writes with generous spacing, and finally reads both data registers and both flags. The mode tests also check the gap between a sample edge and the next launch edge. Between those two edges they flip `sdi` and read the data register and `sdo`, which confirms that only the sampling edge captures data.

// File: rtl/ssu_pkg.sv
package ssu_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_PIN = 2'd1,
    SRC_TMR = 2'd2,
    SRC_SW  = 2'd3
  } clk_src_e;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_CNT  = 2'd1,
    REG_CTRL = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;

  // control bit positions
  localparam int unsigned CB_PHASE = 2;
  localparam int unsigned CB_IE    = 3;
  localparam int unsigned CB_TGL   = 4;
  localparam int unsigned CB_MST   = 5;
  localparam int unsigned CB_STEP  = 6;
  // status bit positions
  localparam int unsigned SB_FLAG  = 0;
  localparam int unsigned SB_SCK   = 1;

  typedef struct packed {
    logic     master;
    logic     irq_en;
    logic     late_phase;
    clk_src_e src;
  } ctrl_t;

endpackage

// File: rtl/ssu_edge_detect.sv
module ssu_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic int_lvl_i,
  input  logic use_int_i,
  output logic rise_o,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= lvl;
    end
  end

  // internal level (own clock output) needs no synchronizer
  assign lvl    = use_int_i ? int_lvl_i : sync_q[SYNC_STAGES-1];
  assign rise_o = lvl & ~prev_q;
  assign fall_o = ~lvl & prev_q;

  a_r3_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_o, fall_o}));

endmodule

// File: rtl/ssu_shift_reg.sv
module ssu_shift_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              sample_i,
  input  logic              launch_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o
);

  logic [DATA_W-1:0] sh_q;
  logic              out_q;

  function automatic logic [DATA_W-1:0] shift_in(input logic [DATA_W-1:0] cur,
                                                 input logic bit_in);
    return {cur[DATA_W-2:0], bit_in};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= load_val_i;
      out_q <= load_val_i[DATA_W-1];
    end else begin
      if (sample_i) sh_q <= shift_in(sh_q, sdi_i);
      if (sample_i && launch_i) out_q <= sh_q[DATA_W-2];
      else if (launch_i)        out_q <= sh_q[DATA_W-1];
    end
  end

  assign data_o = sh_q;
  assign sdo_o  = out_q;

  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !load_i) |=> (sh_q[DATA_W-1] == $past(sh_q[DATA_W-2])));

  a_r4_launch_holds_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && !sample_i && !load_i) |=> (sdo_o == $past(sh_q[DATA_W-1])));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (data_o == $past(load_val_i)));

endmodule

// File: rtl/ssu_edge_counter.sv
module ssu_edge_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic             clr_flag_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic [CNT_W:0]   nxt;

  // carry out of the increment marks the wrap
  function automatic logic [CNT_W:0] step_count(input logic [CNT_W-1:0] c);
    return {1'b0, c} + {{CNT_W{1'b0}}, 1'b1};
  endfunction

  assign nxt    = step_count(cnt_q);
  assign wrap_o = adv_i && !wr_i && nxt[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i)       cnt_q <= wr_val_i;
      else if (adv_i) cnt_q <= nxt[CNT_W-1:0];
      if (wrap_o)          flag_q <= 1'b1;
      else if (clr_flag_i) flag_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !wr_i && (&cnt_q)) |=> (flag_o && cnt_o == '0));

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_flag_i) |=> flag_o);

  a_r9_count_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_o == $past(wr_val_i)));

endmodule

// File: rtl/ssu_top.sv
module ssu_top
  import ssu_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              tmr_match,
  input  logic              sdi,
  output logic              sdo,
  output logic              irq
);

  localparam int unsigned CNT_PAD = DATA_W - CNT_W;

  ctrl_t            ctrl_q;
  logic             sck_q;
  logic             wr_data, wr_cnt, wr_ctrl, wr_stat;
  logic             step_pulse, tgl_pulse;
  logic             pin_rise, pin_fall;
  logic             smp, lau, cnt_adv;
  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             flag_q, wrap_evt;

  assign wr_data    = bus_wr && (bus_addr == REG_DATA);
  assign wr_cnt     = bus_wr && (bus_addr == REG_CNT);
  assign wr_ctrl    = bus_wr && (bus_addr == REG_CTRL);
  assign wr_stat    = bus_wr && (bus_addr == REG_STAT);
  assign step_pulse = wr_ctrl && bus_wdata[CB_STEP];
  assign tgl_pulse  = wr_ctrl && bus_wdata[CB_TGL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sck_q  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.src        <= clk_src_e'(bus_wdata[1:0]);
        ctrl_q.late_phase <= bus_wdata[CB_PHASE];
        ctrl_q.irq_en     <= bus_wdata[CB_IE];
        ctrl_q.master     <= bus_wdata[CB_MST];
      end
      if (tgl_pulse)    sck_q <= ~sck_q;
      else if (wr_stat) sck_q <= bus_wdata[SB_SCK];
    end
  end

  ssu_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (sck_in),
    .int_lvl_i (sck_q),
    .use_int_i (ctrl_q.master),
    .rise_o    (pin_rise),
    .fall_o    (pin_fall)
  );

  // clock source and phase routing
  always_comb begin
    smp     = 1'b0;
    lau     = 1'b0;
    cnt_adv = 1'b0;
    unique case (ctrl_q.src)
      SRC_PIN: begin
        smp     = ctrl_q.late_phase ? pin_fall : pin_rise;
        lau     = ctrl_q.late_phase ? pin_rise : pin_fall;
        cnt_adv = pin_rise | pin_fall;
      end
      SRC_TMR: begin
        smp     = tmr_match;
        lau     = tmr_match;
        cnt_adv = tmr_match;
      end
      SRC_SW: begin
        smp     = step_pulse;
        lau     = step_pulse;
        cnt_adv = step_pulse;
      end
      default: ;
    endcase
  end

  ssu_shift_reg #(.DATA_W(DATA_W)) shreg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_data),
    .load_val_i (bus_wdata),
    .sample_i   (smp),
    .launch_i   (lau),
    .sdi_i      (sdi),
    .data_o     (data_q),
    .sdo_o      (sdo)
  );

  ssu_edge_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .adv_i      (cnt_adv),
    .wr_i       (wr_cnt),
    .wr_val_i   (bus_wdata[CNT_W-1:0]),
    .clr_flag_i (wr_stat && bus_wdata[SB_FLAG]),
    .cnt_o      (cnt_q),
    .flag_o     (flag_q),
    .wrap_o     (wrap_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      REG_DATA: bus_rdata = data_q;
      REG_CNT:  bus_rdata = {{CNT_PAD{1'b0}}, cnt_q};
      REG_CTRL: begin
        bus_rdata[1:0]      = ctrl_q.src;
        bus_rdata[CB_PHASE] = ctrl_q.late_phase;
        bus_rdata[CB_IE]    = ctrl_q.irq_en;
        bus_rdata[CB_MST]   = ctrl_q.master;
      end
      default: begin
        bus_rdata[SB_FLAG] = flag_q;
        bus_rdata[SB_SCK]  = sck_q;
      end
    endcase
  end

  assign sck_out = sck_q;
  assign irq     = flag_q & ctrl_q.irq_en;

  a_r10_off_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src == SRC_OFF && !wr_cnt) |=> $stable(cnt_q));

  a_r10_off_holds_data: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.src == SRC_OFF && !wr_data) |=> $stable(data_q));

  a_r8_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_pulse |=> (sck_out != $past(sck_out)));

  a_r5_irq_needs_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap_evt) || $rose(ctrl_q.irq_en)));

endmodule

// File: tb/ssu_top_tb_top.sv
`timescale 1ns/1ps
module ssu_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] d_addr = '0, p_addr = '0;
  logic       d_wr = 1'b0, p_wr = 1'b0;
  logic [7:0] d_wd = '0, p_wd = '0, d_rd, p_rd;
  logic       tb_sck = 1'b0, tb_tmr = 1'b0, tb_sdi = 1'b0, link = 1'b0;
  logic       d_sck_out, p_sck_out, d_sdo, p_sdo, d_irq, p_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ssu_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(d_addr), .bus_wr(d_wr), .bus_wdata(d_wd),
    .bus_rdata(d_rd), .sck_in(tb_sck), .sck_out(d_sck_out), .tmr_match(tb_tmr),
    .sdi(link ? p_sdo : tb_sdi), .sdo(d_sdo), .irq(d_irq)
  );

  ssu_top peer_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(p_addr), .bus_wr(p_wr), .bus_wdata(p_wd),
    .bus_rdata(p_rd), .sck_in(d_sck_out), .sck_out(p_sck_out), .tmr_match(1'b0),
    .sdi(d_sdo), .sdo(p_sdo), .irq(p_irq)
  );

  localparam logic [1:0] A_DATA = 2'd0, A_CNT = 2'd1, A_CTRL = 2'd2, A_STAT = 2'd3;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int u, input logic [1:0] a, input logic [7:0] v);
    @(negedge clk);
    if (u == 0) begin d_addr = a; d_wd = v; d_wr = 1'b1; end
    else        begin p_addr = a; p_wd = v; p_wr = 1'b1; end
    @(negedge clk);
    d_wr = 1'b0;
    p_wr = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input int u, input logic [1:0] a, input logic [7:0] exp,
                         input string tag);
    logic [7:0] v;
    @(negedge clk);
    if (u == 0) begin d_addr = a; #1 v = d_rd; end
    else        begin p_addr = a; #1 v = p_rd; end
    chk(tag, v, exp);
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tb_tmr = 1'b1;
    @(negedge clk); tb_tmr = 1'b0;
    idle(1);
  endtask

  task automatic pin_edge(input logic lvl);
    @(negedge clk); tb_sck = lvl;
    idle(6);
  endtask

  task automatic t_reset();
    chk_reg(0, A_DATA, 8'h00, "R1 data");
    chk_reg(0, A_CNT,  8'h00, "R1 count");
    chk_reg(0, A_CTRL, 8'h00, "R1 ctrl");
    chk_reg(0, A_STAT, 8'h00, "R1 status");
    chk("R1 sdo/sck_out/irq", {5'd0, d_sdo, d_sck_out, d_irq}, 8'h00);
  endtask

  task automatic t_pin_mode0();
    logic [7:0] pat = 8'h3C;
    wr(0, A_CTRL, 8'h09);
    wr(0, A_DATA, 8'hA5);
    wr(0, A_CNT, 8'h00);
    chk("R3 write presets sdo", {7'd0, d_sdo}, 8'h01);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); tb_sdi = pat[i];
      pin_edge(1'b1);
      if (i == 7) begin
        chk_reg(0, A_DATA, 8'h4A, "R3 rise samples");
        chk_reg(0, A_CNT, 8'h01, "R3 rise counts");
        chk("R3 sdo held on rise", {7'd0, d_sdo}, 8'h01);
      end
      tb_sdi = ~pat[i];
      pin_edge(1'b0);
      if (i == 7) begin
        chk("R3 fall launches", {7'd0, d_sdo}, 8'h00);
        chk_reg(0, A_DATA, 8'h4A, "R3 fall no sample");
        chk_reg(0, A_CNT, 8'h02, "R3 fall counts");
      end
    end
    chk_reg(0, A_DATA, 8'h3C, "R3 byte received");
    chk_reg(0, A_CNT, 8'h00, "R5 count wrapped");
    chk_reg(0, A_STAT, 8'h01, "R5 flag set");
    chk("R5 irq with enable", {7'd0, d_irq}, 8'h01);
    wr(0, A_STAT, 8'h01);
    chk_reg(0, A_STAT, 8'h00, "R5 flag cleared");
    chk("R5 irq dropped", {7'd0, d_irq}, 8'h00);
  endtask

  task automatic t_pin_mode1();
    logic [7:0] pat = 8'hC3;
    wr(0, A_CTRL, 8'h05);
    wr(0, A_DATA, 8'h81);
    wr(0, A_CNT, 8'h00);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); tb_sdi = ~pat[i];
      pin_edge(1'b1);
      if (i == 7) begin
        chk_reg(0, A_DATA, 8'h81, "R4 rise no sample");
        chk_reg(0, A_CNT, 8'h01, "R4 rise counts");
      end
      tb_sdi = pat[i];
      pin_edge(1'b0);
      if (i == 7) begin
        chk_reg(0, A_DATA, 8'h03, "R4 fall samples");
        chk("R4 sdo held on fall", {7'd0, d_sdo}, 8'h01);
      end
    end
    chk_reg(0, A_DATA, 8'hC3, "R4 byte received");
    chk_reg(0, A_STAT, 8'h01, "R5 flag mode1");
    chk("R5 irq masked", {7'd0, d_irq}, 8'h00);
    wr(0, A_STAT, 8'h01);
  endtask

  task automatic t_timer();
    logic [7:0] pat = 8'h96;
    wr(0, A_CTRL, 8'h02);
    wr(0, A_DATA, 8'h00);
    wr(0, A_CNT, 8'h08);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); tb_sdi = pat[i];
      pulse_tmr();
      if (i == 1) begin
        chk_reg(0, A_CNT, 8'h0F, "R6 seven strobes");
        chk_reg(0, A_STAT, 8'h00, "R5 no flag before wrap");
      end
    end
    chk_reg(0, A_DATA, 8'h96, "R6 byte by timer");
    chk_reg(0, A_STAT, 8'h01, "R5 flag on preset 8");
    chk("R6 sdo follows msb", {7'd0, d_sdo}, 8'h01);
    pin_edge(1'b1);
    pin_edge(1'b0);
    wr(0, A_CTRL, 8'h42);
    chk_reg(0, A_CNT, 8'h00, "R6 other sources ignored");
    chk_reg(0, A_DATA, 8'h96, "R6 data untouched");
    wr(0, A_STAT, 8'h01);
  endtask

  task automatic t_step();
    wr(0, A_CTRL, 8'h03);
    wr(0, A_DATA, 8'h0F);
    wr(0, A_CNT, 8'h03);
    @(negedge clk); tb_sdi = 1'b1;
    wr(0, A_CTRL, 8'h43);
    chk_reg(0, A_CNT, 8'h04, "R7 step counts");
    chk_reg(0, A_DATA, 8'h1F, "R7 step shifts");
    chk_reg(0, A_CTRL, 8'h03, "R2 step reads zero");
    pulse_tmr();
    chk_reg(0, A_CNT, 8'h04, "R7 timer ignored");
    chk("R7 sdo msb", {7'd0, d_sdo}, 8'h00);
  endtask

  task automatic t_off();
    wr(0, A_CTRL, 8'h00);
    pulse_tmr();
    wr(0, A_CTRL, 8'h40);
    pin_edge(1'b1);
    pin_edge(1'b0);
    chk_reg(0, A_CNT, 8'h04, "R10 count frozen");
    chk_reg(0, A_DATA, 8'h1F, "R10 data frozen");
  endtask

  task automatic t_prio();
    wr(0, A_CTRL, 8'h02);
    wr(0, A_CNT, 8'h05);
    @(negedge clk);
    d_addr = A_CNT; d_wd = 8'h09; d_wr = 1'b1; tb_tmr = 1'b1;
    @(negedge clk);
    d_wr = 1'b0; tb_tmr = 1'b0;
    chk_reg(0, A_CNT, 8'h09, "R9 write beats strobe");
    chk_reg(0, A_DATA, 8'h3F, "R9 shift still done");
  endtask

  task automatic t_link();
    wr(0, A_CTRL, 8'h00);
    wr(0, A_STAT, 8'h01);
    @(negedge clk); link = 1'b1;
    wr(0, A_CTRL, 8'h21);
    wr(1, A_CTRL, 8'h01);
    wr(0, A_DATA, 8'h5A);
    wr(1, A_DATA, 8'hC3);
    wr(0, A_CNT, 8'h00);
    wr(1, A_CNT, 8'h00);
    chk_reg(0, A_CTRL, 8'h21, "R2 ctrl readback");
    for (int k = 0; k < 16; k++) begin
      wr(0, A_CTRL, 8'h31);
      idle(8);
      if (k == 0) chk("R8 toggle raises clock", {7'd0, d_sck_out}, 8'h01);
    end
    chk_reg(0, A_DATA, 8'hC3, "R11 master got peer byte");
    chk_reg(1, A_DATA, 8'h5A, "R11 peer got master byte");
    chk_reg(0, A_STAT, 8'h01, "R11 master flag");
    chk_reg(1, A_STAT, 8'h01, "R11 peer flag");
    wr(0, A_CTRL, 8'h00);
    wr(0, A_STAT, 8'h03);
    chk("R8 direct level write", {7'd0, d_sck_out}, 8'h01);
    chk_reg(0, A_STAT, 8'h02, "R8 level readback");
    wr(0, A_STAT, 8'h00);
    chk("R8 direct level low", {7'd0, d_sck_out}, 8'h00);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_pin_mode0();
    t_pin_mode1();
    t_timer();
    t_step();
    t_off();
    t_prio();
    t_link();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule